// File: doc/BRIEF.md
# Single-Bit Manipulation Unit

This block is a purely combinational datapath slice that sets, clears, inverts or extracts one bit of a register operand. The position of the bit comes either from the low bits of a second register operand or from a 6-bit immediate field, chosen by a select flag. The result is produced in the same cycle as the inputs, and the block holds no state.

The unit is built for a 32-bit or a 64-bit datapath. It decodes the bit position once into a one-hot mask, and all four operations use that mask. For the 32-bit build, an immediate position that needs a sixth bit cannot address a real bit. The block raises a flag for that case, and the surrounding pipeline can raise an illegal-instruction trap from it. Decode, trapping and forwarding belong to the surrounding pipeline.

Top module: `single_bit_unit`

## Requirements
- R1: With operation code 2'b00 (set), the result equals the operand with the selected bit forced to 1 and every other bit unchanged.
- R2: With operation code 2'b01 (clear), the result equals the operand with the selected bit forced to 0 and every other bit unchanged.
- R3: With operation code 2'b10 (invert), the result equals the operand with the selected bit complemented and every other bit unchanged.
- R4: With operation code 2'b11 (extract), result bit 0 equals the selected operand bit and all other result bits are 0.
- R5: The bit position is taken from the low log2(XLEN) bits of the chosen index source. Higher bits of the register index, and bit 5 of the immediate in the 32-bit build, do not affect the result.
- R6: When `use_imm` is 1, the position comes from `index_imm`; when it is 0, it comes from `index_reg`. For the same position, both forms give identical results.
- R7: `imm_illegal` is 1 only in the 32-bit build, when `use_imm` is 1 and `index_imm[5]` is 1. It is 0 in every other case.
- R8: `result_out` and `imm_illegal` depend only on the present inputs and follow them within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand_in | input | XLEN | Value whose bit is manipulated |
| index_reg | input | XLEN | Register source of the bit position |
| index_imm | input | 6 | Immediate source of the bit position |
| use_imm | input | 1 | 1 selects the immediate position, 0 the register position |
| op_sel | input | 2 | Operation: 00 set, 01 clear, 10 invert, 11 extract |
| result_out | output | XLEN | Full-width result |
| imm_illegal | output | 1 | Immediate position out of range for this width |

## Verification
The block has no state, so a fault in the position decode or the mask is visible at once at `result_out`, in the same cycle as the inputs that expose it. A mask that is not one-hot, or that points at the wrong bit, shows up as more than one changed bit or as the wrong changed bit. The bench therefore sweeps every bit position under several operand patterns, in both index forms. It puts noise in the ignored index bits, so a decoder that reads those bits produces a wrong result on the first affected vector.

// File: rtl/sbit_pkg.sv
package sbit_pkg;
  localparam int SB_IMM_W = 6;

  typedef enum logic [1:0] {
    SB_SET = 2'b00,
    SB_CLR = 2'b01,
    SB_INV = 2'b10,
    SB_EXT = 2'b11
  } sbit_op_e;
endpackage

// File: rtl/sbit_index_sel.sv
module sbit_index_sel #(
  parameter int XLEN = 64,
  parameter int IDXW = $clog2(XLEN)
) (
  input  logic [XLEN-1:0]              index_reg,
  input  logic [sbit_pkg::SB_IMM_W-1:0] index_imm,
  input  logic                          use_imm,
  output logic [IDXW-1:0]               idx,
  output logic                          imm_bad
);
  logic unused_reg_hi;
  assign unused_reg_hi = ^index_reg[XLEN-1:IDXW];

  function automatic logic [IDXW-1:0] pick(input logic [XLEN-1:0] r,
                                           input logic [sbit_pkg::SB_IMM_W-1:0] m,
                                           input logic sel);
    return sel ? m[IDXW-1:0] : r[IDXW-1:0];
  endfunction

  assign idx = pick(index_reg, index_imm, use_imm);

  generate
    if (IDXW < sbit_pkg::SB_IMM_W) begin : g_narrow
      assign imm_bad = use_imm & (|index_imm[sbit_pkg::SB_IMM_W-1:IDXW]);
    end else begin : g_wide
      assign imm_bad = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/sbit_mask_dec.sv
module sbit_mask_dec #(
  parameter int XLEN = 64,
  parameter int IDXW = $clog2(XLEN)
) (
  input  logic [IDXW-1:0] idx,
  output logic [XLEN-1:0] mask
);
  generate
    for (genvar b = 0; b < XLEN; b++) begin : g_bit
      assign mask[b] = (idx == IDXW'(b));
    end
  endgenerate
endmodule

// File: rtl/sbit_apply.sv
module sbit_apply #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0]      operand,
  input  logic [XLEN-1:0]      mask,
  input  sbit_pkg::sbit_op_e   op,
  output logic [XLEN-1:0]      result,
  output logic                 picked
);
  import sbit_pkg::*;

  function automatic logic bit_rule(input logic v, input logic hit, input sbit_op_e o);
    case (o)
      SB_SET:  return v | hit;
      SB_CLR:  return v & ~hit;
      SB_INV:  return v ^ hit;
      default: return 1'b0;
    endcase
  endfunction

  assign picked = |(operand & mask);

  generate
    for (genvar b = 0; b < XLEN; b++) begin : g_lane
      if (b == 0) begin : g_low
        assign result[b] = (op == SB_EXT) ? picked : bit_rule(operand[b], mask[b], op);
      end else begin : g_high
        assign result[b] = bit_rule(operand[b], mask[b], op);
      end
    end
  endgenerate
endmodule

// File: rtl/single_bit_unit.sv
module single_bit_unit #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0]              operand_in,
  input  logic [XLEN-1:0]              index_reg,
  input  logic [sbit_pkg::SB_IMM_W-1:0] index_imm,
  input  logic                          use_imm,
  input  logic [1:0]                    op_sel,
  output logic [XLEN-1:0]               result_out,
  output logic                          imm_illegal
);
  localparam int IDXW = $clog2(XLEN);

  logic [IDXW-1:0]    idx_w;
  logic [XLEN-1:0]    mask_w;
  logic               picked_w;
  sbit_pkg::sbit_op_e op_w;

  assign op_w = sbit_pkg::sbit_op_e'(op_sel);

  sbit_index_sel #(.XLEN(XLEN), .IDXW(IDXW)) u_sel (
    .index_reg (index_reg),
    .index_imm (index_imm),
    .use_imm   (use_imm),
    .idx       (idx_w),
    .imm_bad   (imm_illegal)
  );

  sbit_mask_dec #(.XLEN(XLEN), .IDXW(IDXW)) u_dec (
    .idx  (idx_w),
    .mask (mask_w)
  );

  sbit_apply #(.XLEN(XLEN)) u_apply (
    .operand (operand_in),
    .mask    (mask_w),
    .op      (op_w),
    .result  (result_out),
    .picked  (picked_w)
  );
endmodule

// File: rtl/single_bit_unit_chk.sv
module single_bit_unit_chk #(
  parameter int XLEN = 64,
  parameter int IDXW = $clog2(XLEN)
) (
  input logic [XLEN-1:0] operand_in,
  input logic [XLEN-1:0] result_out,
  input logic [1:0]      op_sel,
  input logic            use_imm,
  input logic [5:0]      index_imm,
  input logic            imm_illegal,
  input logic [XLEN-1:0] mask_w,
  input logic [IDXW-1:0] idx_w
);
  always_comb begin
    AST_MASK_ONEHOT: assert ($onehot(mask_w)) else $error("mask not one-hot"); // R5
    if (op_sel == 2'b00) begin
      AST_SET_ONE_BIT: assert (result_out[idx_w] && $countones(result_out ^ operand_in) <= 1) else $error("set wrong"); // R1
    end
    if (op_sel == 2'b01) begin
      AST_CLR_ONE_BIT: assert (!result_out[idx_w] && $countones(result_out ^ operand_in) <= 1) else $error("clear wrong"); // R2
    end
    if (op_sel == 2'b10) begin
      AST_INV_ONE_BIT: assert ($countones(result_out ^ operand_in) == 1 && result_out[idx_w] != operand_in[idx_w]) else $error("invert wrong"); // R3
    end
    if (op_sel == 2'b11) begin
      AST_EXT_ZERO_UPPER: assert (result_out[XLEN-1:1] == '0 && result_out[0] == operand_in[idx_w]) else $error("extract wrong"); // R4
    end
    if (imm_illegal) begin
      AST_FLAG_IMM_ONLY: assert (use_imm && index_imm[5] && XLEN == 32) else $error("flag wrong"); // R7
    end
  end
endmodule

bind single_bit_unit single_bit_unit_chk #(.XLEN(XLEN)) u_chk (
  .operand_in  (operand_in),
  .result_out  (result_out),
  .op_sel      (op_sel),
  .use_imm     (use_imm),
  .index_imm   (index_imm),
  .imm_illegal (imm_illegal),
  .mask_w      (mask_w),
  .idx_w       (idx_w)
);

// File: tb/single_bit_unit_bench.sv
module single_bit_unit_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [63:0] operand;
  logic [63:0] index_reg;
  logic [5:0]  index_imm;
  logic        use_imm;
  logic [1:0]  op_sel;
  logic [63:0] res64;
  logic [31:0] res32;
  logic        flag64, flag32;

  single_bit_unit #(.XLEN(64)) u_single_bit_unit (
    .operand_in(operand), .index_reg(index_reg), .index_imm(index_imm),
    .use_imm(use_imm), .op_sel(op_sel), .result_out(res64), .imm_illegal(flag64));

  single_bit_unit #(.XLEN(32)) u_single_bit_unit_w32 (
    .operand_in(operand[31:0]), .index_reg(index_reg[31:0]), .index_imm(index_imm),
    .use_imm(use_imm), .op_sel(op_sel), .result_out(res32), .imm_illegal(flag32));

  typedef struct {
    logic [63:0] e64;
    logic [31:0] e32;
    logic        f64;
    logic        f32;
    string       tag;
  } item_t;

  item_t sb_q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  function automatic logic [63:0] model(input logic [63:0] a, input int w,
                                        input int pos, input logic [1:0] op);
    logic [63:0] r;
    logic        b;
    r = '0;
    for (int k = 0; k < w; k++) r[k] = a[k];
    b = a[pos];
    case (op)
      2'b00: r[pos] = 1'b1;
      2'b01: r[pos] = 1'b0;
      2'b10: r[pos] = ~r[pos];
      default: begin r = '0; r[0] = b; end
    endcase
    return r;
  endfunction

  task automatic drive(input logic [1:0] op, input logic [63:0] a, input logic [63:0] ireg,
                       input logic [5:0] imm, input logic sel, input string tag);
    item_t it;
    int p64, p32;
    logic [63:0] t;
    @(posedge clk);
    #1;
    op_sel = op; operand = a; index_reg = ireg; index_imm = imm; use_imm = sel;
    p64 = sel ? int'(imm) : int'(ireg[5:0]);
    p32 = sel ? int'(imm[4:0]) : int'(ireg[4:0]);
    it.e64 = model(a, 64, p64, op);
    t = model(a, 32, p32, op);
    it.e32 = t[31:0];
    it.f64 = 1'b0;
    it.f32 = sel & imm[5];
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic cmp(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        it = sb_q.pop_front();
        cmp({it.tag, " w64 result"}, res64, it.e64);
        cmp({it.tag, " w32 result"}, {32'd0, res32}, {32'd0, it.e32});
        cmp("R7 w64 flag", {63'd0, flag64}, {63'd0, it.f64});
        cmp("R7 w32 flag", {63'd0, flag32}, {63'd0, it.f32});
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : driver
    logic [63:0] pats [4];
    string tags [4];
    pats[0] = 64'h0;
    pats[1] = '1;
    pats[2] = 64'h5555_AAAA_0F0F_F0F0;
    pats[3] = 64'h8000_0001_7FFF_FFFE;
    tags[0] = "R1"; tags[1] = "R2"; tags[2] = "R3"; tags[3] = "R4";
    operand = '0; index_reg = '0; index_imm = '0; use_imm = 1'b0; op_sel = 2'b00;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R8: idle inputs give set of bit 0 of zero in the same cycle
    drive(2'b00, 64'h0, 64'h0, 6'd0, 1'b0, "R8");
    for (int op = 0; op < 4; op++) begin
      for (int pi = 0; pi < 4; pi++) begin
        for (int pos = 0; pos < 64; pos++) begin
          drive(2'(op), pats[pi], 64'(pos), 6'd0, 1'b0, tags[op]);
          // R5: noise in the upper register index bits
          drive(2'(op), pats[pi], {58'h2A5_C3F0_1234_ABC, 6'(pos)}, 6'd0, 1'b0, {tags[op], "/R5"});
          // R6: immediate form, register index holds a decoy
          drive(2'(op), pats[pi], 64'(63 - pos), 6'(pos), 1'b1, {tags[op], "/R6"});
        end
      end
    end
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule